// File: doc/BRIEF.md
# Multicycle Phase-Sequenced Instruction Core

This block is a small 16-bit processor core driven by a controller that walks each instruction through named phases. The phases are fetch, decode, address evaluation, operand fetch, execute and store result. An instruction skips every phase it has no use for. The core holds eight general registers, a program counter, a memory address register, a memory data register and an instruction register.

Two operations are implemented. The first adds two registers and writes the sum to a third. The second loads a word from memory at a base register plus a signed 6-bit offset. Every other opcode does nothing and returns to fetch right after decode.

Memory is a single port with variable latency. The core raises a read request with an address and holds both until the memory answers with a ready pulse. Each register write appears at the ports as a writeback strobe with its index and data, and the current phase is visible as a 4-bit code. An integrating block can therefore follow execution without any extra access path.

Top module: `phase_core`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears the PC and all eight registers and puts the controller in the first fetch step (phase code 0). While in that step, `mem_rd` and `wb_en` are low.
- R2: Phase codes are: 0 fetch-MAR, 1 fetch-memory, 2 fetch-IR, 3 decode, 4 evaluate-address, 5 operand-from-registers, 6 operand-MAR, 7 operand-memory, 8 execute, 9 store. In phase 1 the core drives `mem_rd` high and puts on `mem_addr` the address of the instruction being fetched. The first fetch after reset reads address 0.
- R3: In phases 1 and 7 the core stays in the phase, with `mem_rd` high and `mem_addr` unchanged, until a cycle in which `mem_ready` is high. It leaves on the next edge and captures `mem_rdata` only in that cycle. `mem_ready` has no effect in any other phase.
- R4: An instruction with opcode bits [15:12] = 0001 goes from phase 3 to phases 5, 8 and 9 in turn, one cycle each. It never visits phase 4.
- R5: For opcode 0001, the store phase writes R[bits 8:6] + R[bits 2:0], modulo 2^16, into R[bits 11:9]. Bits [5:3] have no effect on the result.
- R6: An instruction with opcode 0110 goes from phase 3 to phases 4 and 6, then to phase 7 (held per R3), then to phase 9. It never visits phase 8.
- R7: For opcode 0110, `mem_addr` in phase 7 equals R[bits 8:6] plus bits [5:0] read as a two's-complement number sign-extended to 16 bits, modulo 2^16.
- R8: For opcode 0110, the store phase writes the word returned by memory in phase 7 into R[bits 11:9].
- R9: Any opcode other than 0001 and 0110 goes from phase 3 straight to phase 0, with no register write.
- R10: After phase 9 the core enters phase 0, and the next fetch reads the word one past the previous instruction's address, wrapping modulo 2^16.
- R11: `wb_en` is high only in phase 9 and for exactly one cycle per add or load instruction. A register written by one instruction returns the new value to any later instruction that reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd | output | 1 | Read request, held until `mem_ready` |
| mem_addr | output | 16 | Read address (contents of MAR) |
| mem_rdata | input | 16 | Read data, valid in a cycle with `mem_ready` high |
| mem_ready | input | 1 | Memory has completed the pending read |
| cur_phase | output | 4 | Current phase code (see R2) |
| wb_en | output | 1 | Register write strobe |
| wb_idx | output | 3 | Register index written |
| wb_data | output | 16 | Data written |

## Verification
The assertions assume that `mem_ready` is held only as long as the memory needs, without any upper bound on the wait. They also assume that `rst` is asserted from time zero for at least one edge. Ready may be asserted in any phase, so the properties on the wait phases rely only on the core keeping the address steady.

The stimulus meets these assumptions with a bench memory model. It answers each read after a random wait of zero to four cycles, and it also raises `mem_ready` at random while no read is pending. The program mixes random adds, loads and undefined opcodes with directed cases: an add of cleared registers, loads at the largest positive and negative offsets, and an add whose sum overflows 16 bits.

// File: rtl/phase_pkg.sv
package phase_pkg;

  typedef enum logic [3:0] {
    PH_FETCH_MAR = 4'd0,
    PH_FETCH_MEM = 4'd1,
    PH_FETCH_IR  = 4'd2,
    PH_DECODE    = 4'd3,
    PH_EVAL_ADDR = 4'd4,
    PH_OPND_REG  = 4'd5,
    PH_OPND_MAR  = 4'd6,
    PH_OPND_MEM  = 4'd7,
    PH_EXECUTE   = 4'd8,
    PH_STORE     = 4'd9
  } phase_t;

  typedef enum logic [1:0] {
    ALU_ADD  = 2'd0,
    ALU_AND  = 2'd1,
    ALU_NOT  = 2'd2,
    ALU_PASS = 2'd3
  } alu_op_t;

  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;

endpackage

// File: rtl/phase_regfile.sv
module phase_regfile #(
  parameter int DW = 16,
  parameter int RN = 8,
  localparam int IW = $clog2(RN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data
);

  logic [DW-1:0] regs [RN];

  for (genvar g = 0; g < RN; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)
        regs[g] <= '0;
      else if (we && widx == IW'(g))
        regs[g] <= wdata;
    end
  end

  assign ra_data = regs[ra_idx];
  assign rb_data = regs[rb_idx];

endmodule

// File: rtl/phase_alu.sv
module phase_alu
  import phase_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_t       op,
  output logic [DW-1:0] y
);

  function automatic logic [DW-1:0] alu_f(input logic [DW-1:0] x,
                                          input logic [DW-1:0] z,
                                          input alu_op_t       k);
    case (k)
      ALU_ADD: return x + z;
      ALU_AND: return x & z;
      ALU_NOT: return ~x;
      default: return x;
    endcase
  endfunction

  assign y = alu_f(a, b, op);

endmodule

// File: rtl/phase_ctrl.sv
module phase_ctrl
  import phase_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   is_add,
  input  logic   is_ldr,
  input  logic   mem_ready,
  output phase_t phase
);

  phase_t nxt;

  always_comb begin
    case (phase)
      PH_FETCH_MAR: nxt = PH_FETCH_MEM;
      PH_FETCH_MEM: nxt = mem_ready ? PH_FETCH_IR : PH_FETCH_MEM;
      PH_FETCH_IR:  nxt = PH_DECODE;
      PH_DECODE:    nxt = is_add ? PH_OPND_REG :
                          is_ldr ? PH_EVAL_ADDR : PH_FETCH_MAR;
      PH_EVAL_ADDR: nxt = PH_OPND_MAR;
      PH_OPND_REG:  nxt = PH_EXECUTE;
      PH_OPND_MAR:  nxt = PH_OPND_MEM;
      PH_OPND_MEM:  nxt = mem_ready ? PH_STORE : PH_OPND_MEM;
      PH_EXECUTE:   nxt = PH_STORE;
      default:      nxt = PH_FETCH_MAR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH_MAR;
    else     phase <= nxt;
  end

endmodule

// File: rtl/phase_core.sv
module phase_core
  import phase_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int REG_N  = 8,
  parameter int OFF_W  = 6,
  localparam int IDX_W = $clog2(REG_N),
  localparam int HOT_W = 1 << OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_rd,
  output logic [DATA_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready,
  output logic [3:0]        cur_phase,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [DATA_W-1:0] wb_data
);

  function automatic logic [DATA_W-1:0] sext_off(input logic [OFF_W-1:0] f);
    return {{(DATA_W-OFF_W){f[OFF_W-1]}}, f};
  endfunction

  function automatic logic [DATA_W-1:0] ea_calc(input logic [DATA_W-1:0] base,
                                                input logic [OFF_W-1:0]  off);
    return base + sext_off(off);
  endfunction

  phase_t phase;
  logic [DATA_W-1:0] pc, mar, mdr, ir, ea, opa, opb, res;
  logic [DATA_W-1:0] ra_data, rb_data, alu_y, bus;
  logic [HOT_W-1:0]  opc_hot;
  logic              opc_add, opc_ldr;
  logic              fetch_go, mdr_load, alu_gate;
  alu_op_t           alu_sel;
  logic [IDX_W-1:0]  dst_idx, sr1_idx, sr2_idx;

  // decode of the instruction register
  assign opc_hot = HOT_W'(1) << ir[DATA_W-1 -: OPC_W];
  assign opc_add = |(opc_hot & (HOT_W'(1) << OPC_ADD));
  assign opc_ldr = |(opc_hot & (HOT_W'(1) << OPC_LDR));
  assign dst_idx = ir[11:9];
  assign sr1_idx = ir[8:6];
  assign sr2_idx = ir[2:0];

  // named internal events
  assign fetch_go = (phase == PH_FETCH_MAR);
  assign mem_rd   = (phase == PH_FETCH_MEM) || (phase == PH_OPND_MEM);
  assign mdr_load = mem_rd && mem_ready;
  assign alu_gate = (phase == PH_EXECUTE);
  assign alu_sel  = alu_gate ? ALU_ADD : ALU_PASS;
  assign bus      = alu_gate ? alu_y : mdr;

  phase_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .is_add    (opc_add),
    .is_ldr    (opc_ldr),
    .mem_ready (mem_ready),
    .phase     (phase)
  );

  phase_regfile #(.DW(DATA_W), .RN(REG_N)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (wb_en),
    .widx    (wb_idx),
    .wdata   (wb_data),
    .ra_idx  (sr1_idx),
    .ra_data (ra_data),
    .rb_idx  (sr2_idx),
    .rb_data (rb_data)
  );

  phase_alu #(.DW(DATA_W)) u_alu (
    .a  (opa),
    .b  (opb),
    .op (alu_sel),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      ea  <= '0;
      opa <= '0;
      opb <= '0;
      res <= '0;
    end else begin
      if (fetch_go) begin
        mar <= pc;
        pc  <= pc + DATA_W'(1);
      end
      if (mdr_load)                 mdr <= mem_rdata;
      if (phase == PH_FETCH_IR)     ir  <= mdr;
      if (phase == PH_EVAL_ADDR)    ea  <= ea_calc(ra_data, ir[OFF_W-1:0]);
      if (phase == PH_OPND_REG) begin
        opa <= ra_data;
        opb <= rb_data;
      end
      if (phase == PH_OPND_MAR)     mar <= ea;
      if (alu_gate)                 res <= bus;
    end
  end

  assign mem_addr  = mar;
  assign cur_phase = phase;
  assign wb_en     = (phase == PH_STORE);
  assign wb_idx    = dst_idx;
  assign wb_data   = opc_ldr ? mdr : res;

endmodule

// File: rtl/phase_core_chk.sv
module phase_core_chk
  import phase_pkg::*;
#(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    phase,
  input logic          mem_rd,
  input logic          mem_ready,
  input logic [DW-1:0] mem_addr,
  input logic          wb_en,
  input logic          opc_add,
  input logic          opc_ldr,
  input logic [DW-1:0] pc
);

  // R3: a pending read keeps its request and address
  a_r3_hold_read: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  // R4: add goes from decode to register operand fetch
  a_r4_add_skips_eval: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECODE && opc_add) |=> (phase == PH_OPND_REG));

  // R6: load leaves operand memory straight for store
  a_r6_ldr_skips_exec: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OPND_MEM && mem_ready) |=> (phase == PH_STORE));

  // R9: undefined opcodes return to fetch
  a_r9_nop_refetch: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DECODE && !opc_add && !opc_ldr) |=> (phase == PH_FETCH_MAR));

  // R10: fetch step one advances the program counter
  a_r10_pc_step: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH_MAR) |=> (pc == $past(pc) + DW'(1)));

  // R11: write strobe only in store, one cycle long
  a_r11_wb_in_store: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (phase == PH_STORE));
  a_r11_wb_single: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> !wb_en);

endmodule

bind phase_core phase_core_chk #(.DW(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phase     (cur_phase),
  .mem_rd    (mem_rd),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .wb_en     (wb_en),
  .opc_add   (opc_add),
  .opc_ldr   (opc_ldr),
  .pc        (pc)
);

// File: tb/test_phase_core.sv
module test_phase_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic        mem_ready = 1'b0;
  logic [3:0]  cur_phase;
  logic        wb_en;
  logic [2:0]  wb_idx;
  logic [15:0] wb_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  phase_core i_phase_core (
    .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .cur_phase(cur_phase),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  logic [15:0] mem [256];
  logic [15:0] rf [8];

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mk_add(input int d, input int s1, input int s2, input int junk);
    return {4'b0001, 3'(d), 3'(s1), 3'(junk), 3'(s2)};
  endfunction

  function automatic logic [15:0] mk_ldr(input int d, input int b, input int off);
    return {4'b0110, 3'(d), 3'(b), 6'(off)};
  endfunction

  function automatic logic [15:0] exp_ea(input logic [15:0] base, input logic [15:0] word);
    logic signed [15:0] off;
    off = 16'($signed(word[5:0]));
    return base + off;
  endfunction

  function automatic string tag_of(input int ph);
    case (ph)
      1: return "R3";
      3: return "R4";
      4: return "R6";
      5: return "R4";
      6: return "R6";
      7: return "R3";
      8: return "R4";
      9: return "R11";
      default: return "R10";
    endcase
  endfunction

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d cycles", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int exp_ph, prev_ph, waits, retired;
    logic [15:0] pc_m, fetch_a, ir_m, ea_m, ld_m, res_m;
    logic        rdy;
    void'($urandom(1234));

    for (int i = 0; i < 256; i++) begin
      case ($urandom % 5)
        0, 1:    mem[i] = mk_add($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8);
        2, 3:    mem[i] = mk_ldr($urandom % 8, $urandom % 8, $urandom % 64);
        default: mem[i] = {4'($urandom % 16) | 4'b1000, 12'($urandom)};
      endcase
    end
    mem[0] = mk_add(1, 0, 0, 7);     // R5: cleared regs, junk bits set
    mem[1] = mk_ldr(2, 0, 31);       // R7: largest positive offset
    mem[2] = mk_ldr(3, 0, -32);      // R7: largest negative offset
    mem[3] = mk_add(4, 2, 3, 0);     // R5: sum wraps
    mem[4] = 16'hF000;               // R9: undefined opcode
    mem[5] = mk_add(5, 4, 4, 5);     // R11: reads freshly written R4
    mem[31]  = 16'hFFFF;
    mem[224] = 16'h8001;
    for (int i = 0; i < 8; i++) rf[i] = '0;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: state right after reset
    chk("R1 phase", 16'(cur_phase), 16'd0);
    chk("R1 mem_rd", 16'(mem_rd), 16'd0);
    chk("R1 wb_en", 16'(wb_en), 16'd0);

    exp_ph = 0; prev_ph = 0; waits = 0; retired = 0;
    pc_m = '0; fetch_a = '0; ir_m = '0; ea_m = '0; ld_m = '0; res_m = '0;

    while (retired < 400) begin
      chk(tag_of(exp_ph), 16'(cur_phase), 16'(exp_ph));
      if (exp_ph != 9) chk("R11 idle", 16'(wb_en), 16'd0);

      if (mem_rd) begin
        rdy = ($urandom % 3 == 0) || (waits >= 4);
        waits = rdy ? 0 : waits + 1;
      end else begin
        rdy = ($urandom % 4 == 0);   // R3: stray ready
      end
      mem_ready = rdy;
      mem_rdata = rdy ? mem[mem_addr[7:0]] : 16'($urandom);

      prev_ph = exp_ph;
      case (exp_ph)
        0: begin
          fetch_a = pc_m;
          pc_m = pc_m + 16'd1;
          exp_ph = 1;
        end
        1: begin
          chk("R2 fetch addr", mem_addr, fetch_a);
          chk("R2 fetch rd", 16'(mem_rd), 16'd1);
          if (rdy) begin
            ir_m = mem_rdata;
            exp_ph = 2;
          end
        end
        2: exp_ph = 3;
        3: begin
          if (ir_m[15:12] == 4'b0001)      exp_ph = 5;
          else if (ir_m[15:12] == 4'b0110) exp_ph = 4;
          else begin
            exp_ph = 0;              // R9
            retired++;
          end
        end
        4: begin
          ea_m = exp_ea(rf[ir_m[8:6]], ir_m);
          exp_ph = 6;
        end
        5: begin
          res_m = rf[ir_m[8:6]] + rf[ir_m[2:0]];
          exp_ph = 8;
        end
        6: exp_ph = 7;
        7: begin
          chk("R7 load addr", mem_addr, ea_m);
          chk("R3 load rd", 16'(mem_rd), 16'd1);
          if (rdy) begin
            ld_m = mem_rdata;
            exp_ph = 9;
          end
        end
        8: exp_ph = 9;
        default: begin
          chk("R11 wb_en", 16'(wb_en), 16'd1);
          chk("R11 wb_idx", 16'(wb_idx), 16'(ir_m[11:9]));
          if (ir_m[15:12] == 4'b0110) begin
            chk("R8 load data", wb_data, ld_m);
            rf[ir_m[11:9]] = ld_m;
          end else begin
            chk("R5 add sum", wb_data, res_m);
            rf[ir_m[11:9]] = res_m;
          end
          retired++;
          exp_ph = 0;                // R10
        end
      endcase
      @(negedge clk);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule